// File: doc/BRIEF.md
# Tournament Branch Direction Predictor with Confidence Flag

This block guesses the direction of conditional branches for an instruction fetch front end. Three tables of 2-bit saturating counters sit side by side. The first is a per-address table, indexed by the low word-address bits of the branch PC. The second is a history-hashed table, indexed by those PC bits XORed with a register holding the most recent resolved outcomes. The third is a chooser table, also indexed by the PC bits, which selects which of the two component tables gives the final guess. Each counter is trained toward the outcome. The chooser is trained toward whichever component turned out to be right.

Decode logic presents the PC bits on the lookup port. In the same cycle it receives the final direction, both component directions, a confidence flag and the history-hashed index. The pipeline carries that index with the branch. When the branch resolves, the execute stage returns the PC bits, the carried index and the actual outcome on the update port. The confidence flag is raised only when both component counters sit in the same strong state. A fetch unit can use it to decide whether to fill a small instruction buffer or to bypass it.

Top module: `bp_tourney`

## Requirements
- R1: After reset, every component counter holds 1 (weakly not-taken) and every chooser counter holds 2. A lookup right after reset therefore reports not-taken on all three direction outputs and low confidence.
- R2: On each update, both component counters addressed by the update port move one step toward the outcome: up on taken, down on not-taken. They stay at 3 on further taken updates and at 0 on further not-taken updates.
- R3: A component direction output is 1 (taken) when its counter is 2 or 3, and 0 (not-taken) when it is 0 or 1.
- R4: The final direction `lk_taken` equals the history-hashed component's direction when the chooser counter at `lk_pc` is 2 or 3. It equals the per-address component's direction when the chooser counter is 0 or 1.
- R5: The per-address index is `lk_pc`. The history-hashed index `lk_gsh_idx` is `lk_pc` XOR the history register, zero-extended. Each update shifts the actual outcome into bit 0 of the history register (1 = taken), moving older bits toward the MSB. Without an update, the history holds its value.
- R6: On an update, the chooser counter at `up_pc` rises by one, saturating at 3, when only the history-hashed component was right. It falls by one, saturating at 0, when only the per-address component was right. Rightness is judged from the counters as they were before that update.
- R7: The chooser counter is unchanged when both components were right or both were wrong.
- R8: `lk_conf_high` is 1 only when both component counters read by the lookup are 3, or both are 0. Otherwise it is 0.
- R9: Updates take effect at the clock edge that samples `up_valid`, so a lookup in the same cycle sees the values from before that update. Writes go only to the entries named on the update port, never to the entry selected by `lk_pc`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_pc | input | IDX_W | Word-address bits of the branch being decoded |
| lk_taken | output | 1 | Final predicted direction, 1 = taken |
| lk_conf_high | output | 1 | 1 when both components agree in a strong state |
| lk_bim_taken | output | 1 | Direction from the per-address table |
| lk_gsh_taken | output | 1 | Direction from the history-hashed table |
| lk_gsh_idx | output | IDX_W | History-hashed index, to be carried to resolve |
| up_valid | input | 1 | A resolved branch is presented this cycle |
| up_taken | input | 1 | Actual outcome, 1 = taken |
| up_pc | input | IDX_W | Word-address bits of the resolved branch |
| up_gsh_idx | input | IDX_W | History-hashed index carried from lookup |

## Verification
A corrupted counter in either component only becomes visible when a lookup reaches that entry. For the history-hashed table, the lookup must also arrive with a history value that hashes to that entry. A counter that wraps instead of saturating shows up one update later, as a flipped component direction. A chooser that steps the wrong way stays hidden until the two components disagree, and then `lk_taken` follows the wrong one. A history register that shifts wrongly changes `lk_gsh_idx` in the very next cycle, so that fault is the fastest to appear at the ports.

// File: rtl/bp_pkg.sv
package bp_pkg;

    typedef logic [1:0] ctr_t;

    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_INC  = 2'd1,
        OP_DEC  = 2'd2
    } ctr_op_e;

    typedef struct packed {
        ctr_op_e bim;
        ctr_op_e gsh;
        ctr_op_e sel;
    } upd_ops_t;

    localparam ctr_t CTR_MIN     = 2'd0;
    localparam ctr_t CTR_WEAK_NT = 2'd1;
    localparam ctr_t CTR_MID     = 2'd2;
    localparam ctr_t CTR_MAX     = 2'd3;

    // Apply one saturating step to a 2-bit counter.
    function automatic ctr_t ctr_apply(ctr_t v, ctr_op_e op);
        ctr_t r;
        r = v;
        case (op)
            OP_INC:  if (v != CTR_MAX) r = v + 2'd1;
            OP_DEC:  if (v != CTR_MIN) r = v - 2'd1;
            default: r = v;
        endcase
        return r;
    endfunction

    function automatic logic ctr_taken(ctr_t v);
        return v[1];
    endfunction

endpackage

// File: rtl/bp_ctr_table.sv
module bp_ctr_table
    import bp_pkg::*;
#(
    parameter int   IDX_W   = 11,
    parameter ctr_t RST_VAL = CTR_WEAK_NT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output ctr_t             rd_val,
    input  logic [IDX_W-1:0] wr_idx,
    output ctr_t             wr_old,
    input  ctr_op_e          wr_op
);
    localparam int DEPTH = 1 << IDX_W;

    ctr_t mem_q [DEPTH];
    ctr_t wr_d;

    always_comb begin
        wr_d = ctr_apply(mem_q[wr_idx], wr_op);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= RST_VAL;
            end
        end else if (wr_op != OP_HOLD) begin
            mem_q[wr_idx] <= wr_d;
        end
    end

    assign rd_val = mem_q[rd_idx];
    assign wr_old = mem_q[wr_idx];

endmodule

// File: rtl/bp_hist_reg.sv
module bp_hist_reg #(
    parameter int HIST_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              bit_in,
    output logic [HIST_W-1:0] hist
);
    logic [HIST_W-1:0] hist_d;
    logic [HIST_W-1:0] hist_q;

    generate
        if (HIST_W == 1) begin : g_one
            always_comb begin
                hist_d = shift_en ? bit_in : hist_q;
            end
        end else begin : g_many
            always_comb begin
                hist_d = shift_en ? {hist_q[HIST_W-2:0], bit_in} : hist_q;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) hist_q <= '0;
        else        hist_q <= hist_d;
    end

    assign hist = hist_q;

endmodule

// File: rtl/bp_tourney.sv
module bp_tourney
    import bp_pkg::*;
#(
    parameter int IDX_W  = 11,
    parameter int HIST_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] lk_pc,
    output logic             lk_taken,
    output logic             lk_conf_high,
    output logic             lk_bim_taken,
    output logic             lk_gsh_taken,
    output logic [IDX_W-1:0] lk_gsh_idx,
    input  logic             up_valid,
    input  logic             up_taken,
    input  logic [IDX_W-1:0] up_pc,
    input  logic [IDX_W-1:0] up_gsh_idx
);
    localparam int PAD_W = IDX_W - HIST_W;

    logic [HIST_W-1:0] hist_q;
    logic [IDX_W-1:0]  hist_ext;
    ctr_t bim_lk_val, gsh_lk_val, sel_lk_val;
    ctr_t bim_up_old, gsh_up_old, sel_up_old;
    upd_ops_t ops_d;
    logic bim_right, gsh_right;

    generate
        if (PAD_W > 0) begin : g_pad
            assign hist_ext = {{PAD_W{1'b0}}, hist_q};
        end else begin : g_nopad
            assign hist_ext = hist_q;
        end
    endgenerate

    assign lk_gsh_idx = lk_pc ^ hist_ext;

    bp_hist_reg #(.HIST_W(HIST_W)) u_hist (
        .clk(clk), .rst_n(rst_n), .shift_en(up_valid), .bit_in(up_taken), .hist(hist_q)
    );

    bp_ctr_table #(.IDX_W(IDX_W), .RST_VAL(CTR_WEAK_NT)) u_bim (
        .clk(clk), .rst_n(rst_n), .rd_idx(lk_pc), .rd_val(bim_lk_val),
        .wr_idx(up_pc), .wr_old(bim_up_old), .wr_op(ops_d.bim)
    );

    bp_ctr_table #(.IDX_W(IDX_W), .RST_VAL(CTR_WEAK_NT)) u_gsh (
        .clk(clk), .rst_n(rst_n), .rd_idx(lk_gsh_idx), .rd_val(gsh_lk_val),
        .wr_idx(up_gsh_idx), .wr_old(gsh_up_old), .wr_op(ops_d.gsh)
    );

    bp_ctr_table #(.IDX_W(IDX_W), .RST_VAL(CTR_MID)) u_sel (
        .clk(clk), .rst_n(rst_n), .rd_idx(lk_pc), .rd_val(sel_lk_val),
        .wr_idx(up_pc), .wr_old(sel_up_old), .wr_op(ops_d.sel)
    );

    // Update side: which tables step, and in which direction.
    always_comb begin
        bim_right = (ctr_taken(bim_up_old) == up_taken);
        gsh_right = (ctr_taken(gsh_up_old) == up_taken);
        ops_d     = '{bim: OP_HOLD, gsh: OP_HOLD, sel: OP_HOLD};
        if (up_valid) begin
            ops_d.bim = up_taken ? OP_INC : OP_DEC;
            ops_d.gsh = up_taken ? OP_INC : OP_DEC;
            if (gsh_right && !bim_right)      ops_d.sel = OP_INC;
            else if (bim_right && !gsh_right) ops_d.sel = OP_DEC;
        end
    end

    // Lookup side.
    always_comb begin
        lk_bim_taken = ctr_taken(bim_lk_val);
        lk_gsh_taken = ctr_taken(gsh_lk_val);
        lk_taken     = ctr_taken(sel_lk_val) ? lk_gsh_taken : lk_bim_taken;
        lk_conf_high = ((bim_lk_val == CTR_MAX) && (gsh_lk_val == CTR_MAX)) ||
                       ((bim_lk_val == CTR_MIN) && (gsh_lk_val == CTR_MIN));
    end

    // The chooser's old value is read only to keep the write port symmetric.
    logic unused_sel_old;
    assign unused_sel_old = ^sel_up_old;

endmodule

// File: rtl/bp_tourney_chk.sv
module bp_tourney_chk #(
    parameter int IDX_W  = 11,
    parameter int HIST_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              up_valid,
    input logic              up_taken,
    input logic [IDX_W-1:0]  up_pc,
    input logic              lk_taken,
    input logic              lk_conf_high,
    input logic              lk_bim_taken,
    input logic              lk_gsh_taken,
    input logic [HIST_W-1:0] hist,
    input logic [1:0]        bim_old
);
    // R8: a confident lookup always has both components pointing the same way
    a_r8_conf_agree: assert property (@(posedge clk) disable iff (!rst_n)
        lk_conf_high |-> (lk_bim_taken == lk_gsh_taken));

    // R4: when the components agree, the final guess cannot differ
    a_r4_follow_agree: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_bim_taken == lk_gsh_taken) |-> (lk_taken == lk_bim_taken));

    // R5: history holds without an update
    a_r5_hist_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !up_valid |=> $stable(hist));

    // R5: the newest history bit is the outcome just resolved
    a_r5_hist_newest: assert property (@(posedge clk) disable iff (!rst_n)
        up_valid |=> (hist[0] == $past(up_taken)));

    // R2: a counter at 3 stays there on a taken update
    a_r2_sat_top: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && up_taken && bim_old == 2'd3) ##1 (up_pc == $past(up_pc))
        |-> (bim_old == 2'd3));

    // R2: a counter at 0 stays there on a not-taken update
    a_r2_sat_bottom: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && !up_taken && bim_old == 2'd0) ##1 (up_pc == $past(up_pc))
        |-> (bim_old == 2'd0));

endmodule

bind bp_tourney bp_tourney_chk #(.IDX_W(IDX_W), .HIST_W(HIST_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .up_valid(up_valid), .up_taken(up_taken), .up_pc(up_pc),
    .lk_taken(lk_taken), .lk_conf_high(lk_conf_high), .lk_bim_taken(lk_bim_taken),
    .lk_gsh_taken(lk_gsh_taken), .hist(hist_q), .bim_old(bim_up_old)
);

// File: tb/sim_bp_tourney.sv
module sim_bp_tourney;
    localparam int CLK_PERIOD = 10;
    localparam int IDX_W      = 11;
    localparam int HIST_W     = 11;
    localparam int DEPTH      = 1 << IDX_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [IDX_W-1:0] lk_pc = '0;
    logic             lk_taken, lk_conf_high, lk_bim_taken, lk_gsh_taken;
    logic [IDX_W-1:0] lk_gsh_idx;
    logic             up_valid = 1'b0;
    logic             up_taken = 1'b0;
    logic [IDX_W-1:0] up_pc = '0;
    logic [IDX_W-1:0] up_gsh_idx = '0;

    int total = 0;
    int bad   = 0;

    // Reference state built from the requirements
    int bm [DEPTH];
    int gm [DEPTH];
    int sm [DEPTH];
    logic [HIST_W-1:0] mhist;

    always #(CLK_PERIOD/2) clk = ~clk;

    bp_tourney #(.IDX_W(IDX_W), .HIST_W(HIST_W)) u0 (
        .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(lk_taken),
        .lk_conf_high(lk_conf_high), .lk_bim_taken(lk_bim_taken),
        .lk_gsh_taken(lk_gsh_taken), .lk_gsh_idx(lk_gsh_idx),
        .up_valid(up_valid), .up_taken(up_taken), .up_pc(up_pc), .up_gsh_idx(up_gsh_idx)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; up_valid = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            bm[i] = 1; gm[i] = 1; sm[i] = 2;
        end
        mhist = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Lookup and compare every output to the reference state.
    task automatic look(input logic [IDX_W-1:0] p, input string req);
        logic [IDX_W-1:0] gi;
        int eb, eg, et, ec;
        @(negedge clk);
        lk_pc = p;
        #1;
        gi = p ^ IDX_W'(mhist);
        eb = (bm[p] >= 2) ? 1 : 0;
        eg = (gm[gi] >= 2) ? 1 : 0;
        et = (sm[p] >= 2) ? eg : eb;
        ec = ((bm[p] == 3 && gm[gi] == 3) || (bm[p] == 0 && gm[gi] == 0)) ? 1 : 0;
        chk(req, "gsh_idx", int'(lk_gsh_idx), int'(gi));
        chk(req, "bim_taken", int'(lk_bim_taken), eb);
        chk(req, "gsh_taken", int'(lk_gsh_taken), eg);
        chk(req, "taken", int'(lk_taken), et);
        chk(req, "conf", int'(lk_conf_high), ec);
    endtask

    task automatic model_update(input int p, input int g, input logic t);
        int tb;
        logic br, gr;
        tb = t ? 1 : 0;
        br = ((bm[p] >= 2) == t);
        gr = ((gm[g] >= 2) == t);
        if (gr && !br && sm[p] < 3)      sm[p]++;
        else if (br && !gr && sm[p] > 0) sm[p]--;
        if (t) begin
            if (bm[p] < 3) bm[p]++;
            if (gm[g] < 3) gm[g]++;
        end else begin
            if (bm[p] > 0) bm[p]--;
            if (gm[g] > 0) gm[g]--;
        end
        mhist = {mhist[HIST_W-2:0], t};
        if (tb < 0) $display("unreachable");
    endtask

    task automatic upd(input logic [IDX_W-1:0] p, input logic [IDX_W-1:0] g, input logic t);
        @(negedge clk);
        up_valid = 1'b1; up_pc = p; up_gsh_idx = g; up_taken = t;
        @(negedge clk);
        up_valid = 1'b0;
        model_update(int'(p), int'(g), t);
    endtask

    task automatic t_reset();
        do_reset();
        look(11'h000, "R1");
        look(11'h123, "R1");
        look(11'h7FF, "R1");
        chk("R1", "taken after reset", int'(lk_taken), 0);
        chk("R1", "conf after reset", int'(lk_conf_high), 0);
    endtask

    task automatic t_saturate();
        for (int k = 0; k < 4; k++) upd(11'h010, 11'h300 + 11'(k), 1'b1);
        look(11'h010, "R2");
        chk("R3", "bim taken at 3", int'(lk_bim_taken), 1);
        upd(11'h010, 11'h310, 1'b0);
        look(11'h010, "R2");
        chk("R2", "ceiling: one not-taken keeps taken", int'(lk_bim_taken), 1);
        for (int k = 0; k < 4; k++) upd(11'h010, 11'h320 + 11'(k), 1'b0);
        upd(11'h010, 11'h330, 1'b1);
        look(11'h010, "R2");
        chk("R2", "floor: one taken from 0 stays not-taken", int'(lk_bim_taken), 0);
        upd(11'h010, 11'h331, 1'b1);
        look(11'h010, "R3");
        chk("R3", "value 2 predicts taken", int'(lk_bim_taken), 1);
    endtask

    task automatic t_history();
        do_reset();
        upd(11'h050, 11'h050, 1'b1);
        upd(11'h051, 11'h051, 1'b0);
        upd(11'h052, 11'h052, 1'b1);
        look(11'h000, "R5");
        chk("R5", "history 101 hashed index", int'(lk_gsh_idx), 5);
        repeat (4) @(negedge clk);
        look(11'h00F, "R5");
        chk("R5", "history holds while idle", int'(lk_gsh_idx), 11'h00F ^ 11'h005);
    endtask

    task automatic t_chooser();
        // both wrong: chooser stays, then only per-address right: chooser falls
        upd(11'h020, 11'h600, 1'b1);
        upd(11'h020, 11'h601, 1'b1);
        look(11'h020, "R6");
        chk("R6", "chooser now picks per-address", int'(lk_taken), 1);
        // train a history-hashed entry, then make only it right at 0x021
        upd(11'h022, 11'h6A0, 1'b1);
        upd(11'h022, 11'h6A0, 1'b1);
        upd(11'h021, 11'h6A0, 1'b1);
        look(11'h021, "R6");
        // both right: chooser unchanged
        upd(11'h021, 11'h6A0, 1'b1);
        look(11'h021, "R7");
        upd(11'h020, 11'h6A0, 1'b1);
        look(11'h020, "R7");
    endtask

    task automatic t_confidence();
        logic [HIST_W-1:0] h;
        logic [IDX_W-1:0]  x;
        h = (mhist << 3) | HIST_W'(3'b111);
        x = 11'h030 ^ IDX_W'(h);
        for (int k = 0; k < 3; k++) upd(11'h030, x, 1'b1);
        look(11'h030, "R8");
        chk("R8", "both strong taken", int'(lk_conf_high), 1);
        h = mhist << 3;
        x = 11'h031 ^ IDX_W'(h);
        for (int k = 0; k < 3; k++) upd(11'h031, x, 1'b0);
        look(11'h031, "R8");
        chk("R8", "both strong not-taken", int'(lk_conf_high), 1);
        look(11'h032, "R8");
        chk("R8", "weak counters give low", int'(lk_conf_high), 0);
    endtask

    task automatic t_same_cycle();
        @(negedge clk);
        lk_pc = 11'h040;
        up_valid = 1'b1; up_pc = 11'h040; up_gsh_idx = 11'h7F0; up_taken = 1'b1;
        #1;
        chk("R9", "lookup before edge sees old", int'(lk_bim_taken), 0);
        @(negedge clk);
        up_valid = 1'b0;
        model_update(11'h040, 11'h7F0, 1'b1);
        #1;
        chk("R9", "lookup after edge sees new", int'(lk_bim_taken), 1);
        // update targets 0x044 while the lookup points at 0x041
        @(negedge clk);
        lk_pc = 11'h041;
        up_valid = 1'b1; up_pc = 11'h044; up_gsh_idx = 11'h7F1; up_taken = 1'b1;
        @(negedge clk);
        up_valid = 1'b0;
        model_update(11'h044, 11'h7F1, 1'b1);
        look(11'h041, "R9");
        chk("R9", "entry under lookup not written", int'(lk_bim_taken), 0);
        look(11'h044, "R9");
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        bad++; total++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_saturate();
        t_history();
        t_chooser();
        t_confidence();
        t_same_cycle();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule